// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block predicts which loads depend on which earlier stores, so that a load that has conflicted with a store before waits for that store to issue. It keeps two tables. The identifier table is indexed by instruction address and maps a load or store PC to a store-set identifier. The last-store table is indexed by that identifier and holds the sequence number of the youngest dispatched store of the set, together with a counter of the set's in-flight stores.

Training comes from outside: when a violation is found, the store PC and load PC are presented and the two instructions are put into one set. Stores announce themselves on the dispatch port and retire from the prediction on the issue port. The lookup port is combinational and reports whether the presented PC must wait, which store sequence number it waits on, and how many stores of its set are in flight. Squash removes entries younger than a given sequence number, and clear empties everything.

A violation chooses one of four merge cases from the valid bits of the two identifier entries: MG_FRESH (neither valid, new identifier hashed from the load PC), MG_TAKE_STORE (only the store valid, the load adopts its identifier), MG_TAKE_LOAD (only the load valid, the store adopts its identifier) and MG_LOWER (both valid, both take the smaller identifier). Each case moves both identifier entries to the chosen identifier in one cycle. No case depends on an earlier cycle.

Top module: `ssp_top`

## Requirements
- R1: The identifier table entry of a PC is bits [OFFSET_BITS+IDX_W-1:OFFSET_BITS] of the PC (IDX_W = log2 of SSIT_SIZE; defaults OFFSET_BITS=2, SSIT_SIZE=64), so PCs that differ only in bits below OFFSET_BITS or above that field share an entry.
- R2: A violation in which neither PC has a valid identifier entry gives both the identifier (PC ^ (PC >> 10)) mod LFST_SIZE computed from the load PC; two pairs whose load PCs hash alike share one last-store entry.
- R3: A violation in which only one of the two PCs has a valid entry gives the other PC the identifier of the valid one.
- R4: A violation in which both entries are valid sets both to the numerically smaller of the two identifiers.
- R5: A store dispatch (disp_is_store_i=1) whose PC has a valid identifier entry writes its sequence number into that set's last-store entry, marks it valid and increments the set's counter, which saturates at 2^CNT_W-1. A store dispatch with no valid entry, and any load dispatch, change nothing.
- R6: lk_dep_o is 1 only when the lookup PC has a valid identifier entry and that set's last-store entry is valid; lk_seq_o then carries the stored sequence number, otherwise 0. lk_pending_o carries the set's counter when the identifier entry is valid, otherwise 0. The lookup sees the state before the current cycle's updates.
- R7: A store issue (iss_is_store_i=1) whose PC has a valid identifier entry invalidates the set's last-store entry only if it holds the issued sequence number, and decrements the set's counter unless it is zero. A load issue changes nothing.
- R8: A squash invalidates every valid last-store entry whose sequence number is greater (unsigned) than sq_seq_i; entries equal to or older than it stay.
- R9: clr_i invalidates both tables and zeroes all counters, and overrides every other operation of the same cycle.
- R10: Operations in one cycle take effect in the order violation, dispatch, issue, squash: a dispatch or issue sees the identifiers written by a violation of the same cycle, and an issue sees the entry written by a dispatch of the same cycle.
- R11: After reset the block is in the cleared state of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| viol_valid_i | input | 1 | Violation training request |
| viol_st_pc_i | input | PC_W | PC of the store in the violation |
| viol_ld_pc_i | input | PC_W | PC of the load in the violation |
| disp_valid_i | input | 1 | Dispatch of a memory instruction |
| disp_is_store_i | input | 1 | 1 = the dispatched instruction is a store, 0 = a load |
| disp_pc_i | input | PC_W | PC of the dispatched instruction |
| disp_seq_i | input | SEQ_W | Sequence number of the dispatched instruction |
| iss_valid_i | input | 1 | Issue notification |
| iss_is_store_i | input | 1 | 1 = the issued instruction is a store, 0 = a load |
| iss_pc_i | input | PC_W | PC of the issued instruction |
| iss_seq_i | input | SEQ_W | Sequence number of the issued instruction |
| sq_valid_i | input | 1 | Squash request |
| sq_seq_i | input | SEQ_W | Entries younger than this number are removed |
| clr_i | input | 1 | Empty both tables |
| lk_pc_i | input | PC_W | PC to look up |
| lk_dep_o | output | 1 | Lookup PC must wait for a store |
| lk_seq_o | output | SEQ_W | Sequence number of the store to wait on |
| lk_pending_o | output | CNT_W | In-flight store count of the lookup PC's set |

## Verification
The assertions take for granted that sequence numbers only grow between clears and stay below 2^SEQ_W, so that the unsigned compare of a squash means younger, and that inputs are stable across each rising edge. The stimulus drives all inputs half a cycle away from the edge, hands out dispatch numbers from one increasing counter, and picks issue and squash numbers a few steps behind that counter. PCs come from a small pool that makes identifier-table and hash collisions frequent, so all four merge cases, stale issues and counter saturation appear in the random phase as well as in the directed one.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    // Merge case of a violation, encoded as {load entry valid, store entry valid}.
    typedef enum logic [1:0] {
        MG_FRESH      = 2'b00,
        MG_TAKE_STORE = 2'b01,
        MG_TAKE_LOAD  = 2'b10,
        MG_LOWER      = 2'b11
    } merge_e;

endpackage

// File: rtl/ssp_id_table.sv
module ssp_id_table
    import ssp_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int SSIT_SIZE   = 64,
    parameter int LFST_SIZE   = 16,
    parameter int OFFSET_BITS = 2,
    parameter int HASH_SHIFT  = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic                         viol_valid_i,
    input  logic [PC_W-1:0]              viol_st_pc_i,
    input  logic [PC_W-1:0]              viol_ld_pc_i,
    input  logic [PC_W-1:0]              lk_pc_i,
    input  logic [PC_W-1:0]              dp_pc_i,
    input  logic [PC_W-1:0]              is_pc_i,
    output logic                         lk_hit_o,
    output logic [$clog2(LFST_SIZE)-1:0] lk_id_o,
    output logic                         dp_hit_o,
    output logic [$clog2(LFST_SIZE)-1:0] dp_id_o,
    output logic                         is_hit_o,
    output logic [$clog2(LFST_SIZE)-1:0] is_id_o
);

    localparam int IDX_W = $clog2(SSIT_SIZE);
    localparam int ID_W  = $clog2(LFST_SIZE);

    logic [SSIT_SIZE-1:0] vld_q;
    logic [ID_W-1:0]      id_q [SSIT_SIZE];

    logic [IDX_W-1:0] ld_idx, st_idx, lk_idx, dp_idx, is_idx;
    logic             ld_hit, st_hit;
    logic [ID_W-1:0]  ld_id, st_id, tgt_id;
    merge_e           merge_kind;

    function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
        logic [PC_W-1:0] sh;
        sh = pc >> OFFSET_BITS;
        return sh[IDX_W-1:0];
    endfunction

    function automatic logic [ID_W-1:0] hash_of(input logic [PC_W-1:0] pc);
        logic [PC_W-1:0] mix;
        mix = pc ^ (pc >> HASH_SHIFT);
        return mix[ID_W-1:0];
    endfunction

    // Only slices of the PCs take part in indexing and hashing.
    logic unused_pc_bits;
    assign unused_pc_bits = ^{viol_st_pc_i, viol_ld_pc_i, lk_pc_i, dp_pc_i, is_pc_i};

    // Violation merge selection.
    always_comb begin
        ld_idx     = idx_of(viol_ld_pc_i);
        st_idx     = idx_of(viol_st_pc_i);
        ld_hit     = vld_q[ld_idx];
        st_hit     = vld_q[st_idx];
        ld_id      = id_q[ld_idx];
        st_id      = id_q[st_idx];
        merge_kind = merge_e'({ld_hit, st_hit});
        unique case (merge_kind)
            MG_FRESH:      tgt_id = hash_of(viol_ld_pc_i);
            MG_TAKE_STORE: tgt_id = st_id;
            MG_TAKE_LOAD:  tgt_id = ld_id;
            MG_LOWER:      tgt_id = (ld_id < st_id) ? ld_id : st_id;
            default:       tgt_id = hash_of(viol_ld_pc_i);
        endcase
    end

    // Read ports: lookup sees stored state, dispatch and issue see the violation's result.
    always_comb begin
        lk_idx   = idx_of(lk_pc_i);
        lk_hit_o = vld_q[lk_idx];
        lk_id_o  = id_q[lk_idx];

        dp_idx = idx_of(dp_pc_i);
        if (viol_valid_i && (dp_idx == ld_idx || dp_idx == st_idx)) begin
            dp_hit_o = 1'b1;
            dp_id_o  = tgt_id;
        end else begin
            dp_hit_o = vld_q[dp_idx];
            dp_id_o  = id_q[dp_idx];
        end

        is_idx = idx_of(is_pc_i);
        if (viol_valid_i && (is_idx == ld_idx || is_idx == st_idx)) begin
            is_hit_o = 1'b1;
            is_id_o  = tgt_id;
        end else begin
            is_hit_o = vld_q[is_idx];
            is_id_o  = id_q[is_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (clr_i) begin
            vld_q <= '0;
        end else if (viol_valid_i) begin
            vld_q[ld_idx] <= 1'b1;
            vld_q[st_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (viol_valid_i && !clr_i) begin
            id_q[ld_idx] <= tgt_id;
            id_q[st_idx] <= tgt_id;
        end
    end

endmodule

// File: rtl/ssp_store_table.sv
module ssp_store_table #(
    parameter int SEQ_W     = 16,
    parameter int LFST_SIZE = 16,
    parameter int CNT_W     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic                         dp_en_i,
    input  logic [$clog2(LFST_SIZE)-1:0] dp_id_i,
    input  logic [SEQ_W-1:0]             dp_seq_i,
    input  logic                         is_en_i,
    input  logic [$clog2(LFST_SIZE)-1:0] is_id_i,
    input  logic [SEQ_W-1:0]             is_seq_i,
    input  logic                         sq_valid_i,
    input  logic [SEQ_W-1:0]             sq_seq_i,
    input  logic [$clog2(LFST_SIZE)-1:0] lk_id_i,
    output logic                         lk_vld_o,
    output logic [SEQ_W-1:0]             lk_seq_o,
    output logic [CNT_W-1:0]             lk_cnt_o
);

    localparam int              ID_W    = $clog2(LFST_SIZE);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             vld_q [LFST_SIZE];
    logic [SEQ_W-1:0] seq_q [LFST_SIZE];
    logic [CNT_W-1:0] cnt_q [LFST_SIZE];

    for (genvar g = 0; g < LFST_SIZE; g++) begin : g_entry
        localparam logic [ID_W-1:0] MY_ID = ID_W'(g);

        logic             v_n;
        logic [SEQ_W-1:0] s_n;
        logic [CNT_W-1:0] c_n;

        // Dispatch, then issue, then squash.
        always_comb begin
            v_n = vld_q[g];
            s_n = seq_q[g];
            c_n = cnt_q[g];
            if (dp_en_i && dp_id_i == MY_ID) begin
                v_n = 1'b1;
                s_n = dp_seq_i;
                if (c_n != CNT_MAX) c_n = c_n + 1'b1;
            end
            if (is_en_i && is_id_i == MY_ID) begin
                if (v_n && s_n == is_seq_i) v_n = 1'b0;
                if (c_n != '0) c_n = c_n - 1'b1;
            end
            if (sq_valid_i && v_n && s_n > sq_seq_i) v_n = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                cnt_q[g] <= '0;
            end else if (clr_i) begin
                vld_q[g] <= 1'b0;
                cnt_q[g] <= '0;
            end else begin
                vld_q[g] <= v_n;
                cnt_q[g] <= c_n;
            end
        end

        always_ff @(posedge clk) begin
            seq_q[g] <= s_n;
        end
    end

    always_comb begin
        lk_vld_o = vld_q[lk_id_i];
        lk_seq_o = seq_q[lk_id_i];
        lk_cnt_o = cnt_q[lk_id_i];
    end

endmodule

// File: rtl/ssp_top.sv
module ssp_top #(
    parameter int PC_W        = 32,
    parameter int SEQ_W       = 16,
    parameter int SSIT_SIZE   = 64,
    parameter int LFST_SIZE   = 16,
    parameter int OFFSET_BITS = 2,
    parameter int HASH_SHIFT  = 10,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             viol_valid_i,
    input  logic [PC_W-1:0]  viol_st_pc_i,
    input  logic [PC_W-1:0]  viol_ld_pc_i,
    input  logic             disp_valid_i,
    input  logic             disp_is_store_i,
    input  logic [PC_W-1:0]  disp_pc_i,
    input  logic [SEQ_W-1:0] disp_seq_i,
    input  logic             iss_valid_i,
    input  logic             iss_is_store_i,
    input  logic [PC_W-1:0]  iss_pc_i,
    input  logic [SEQ_W-1:0] iss_seq_i,
    input  logic             sq_valid_i,
    input  logic [SEQ_W-1:0] sq_seq_i,
    input  logic             clr_i,
    input  logic [PC_W-1:0]  lk_pc_i,
    output logic             lk_dep_o,
    output logic [SEQ_W-1:0] lk_seq_o,
    output logic [CNT_W-1:0] lk_pending_o
);

    localparam int ID_W = $clog2(LFST_SIZE);

    logic            lk_hit, dp_hit, is_hit;
    logic [ID_W-1:0] lk_id, dp_id, is_id;
    logic            st_disp_en, st_iss_en;
    logic            lf_vld;
    logic [SEQ_W-1:0] lf_seq;
    logic [CNT_W-1:0] lf_cnt;

    assign st_disp_en = disp_valid_i && disp_is_store_i && dp_hit;
    assign st_iss_en  = iss_valid_i && iss_is_store_i && is_hit;

    ssp_id_table #(
        .PC_W        (PC_W),
        .SSIT_SIZE   (SSIT_SIZE),
        .LFST_SIZE   (LFST_SIZE),
        .OFFSET_BITS (OFFSET_BITS),
        .HASH_SHIFT  (HASH_SHIFT)
    ) u_ids (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (clr_i),
        .viol_valid_i (viol_valid_i),
        .viol_st_pc_i (viol_st_pc_i),
        .viol_ld_pc_i (viol_ld_pc_i),
        .lk_pc_i      (lk_pc_i),
        .dp_pc_i      (disp_pc_i),
        .is_pc_i      (iss_pc_i),
        .lk_hit_o     (lk_hit),
        .lk_id_o      (lk_id),
        .dp_hit_o     (dp_hit),
        .dp_id_o      (dp_id),
        .is_hit_o     (is_hit),
        .is_id_o      (is_id)
    );

    ssp_store_table #(
        .SEQ_W     (SEQ_W),
        .LFST_SIZE (LFST_SIZE),
        .CNT_W     (CNT_W)
    ) u_stores (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .dp_en_i    (st_disp_en),
        .dp_id_i    (dp_id),
        .dp_seq_i   (disp_seq_i),
        .is_en_i    (st_iss_en),
        .is_id_i    (is_id),
        .is_seq_i   (iss_seq_i),
        .sq_valid_i (sq_valid_i),
        .sq_seq_i   (sq_seq_i),
        .lk_id_i    (lk_id),
        .lk_vld_o   (lf_vld),
        .lk_seq_o   (lf_seq),
        .lk_cnt_o   (lf_cnt)
    );

    always_comb begin
        lk_dep_o     = lk_hit && lf_vld;
        lk_seq_o     = lk_dep_o ? lf_seq : '0;
        lk_pending_o = lk_hit ? lf_cnt : '0;
    end

endmodule

// File: rtl/ssp_top_checker.sv
module ssp_top_checker #(
    parameter int PC_W  = 32,
    parameter int SEQ_W = 16,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             viol_valid_i,
    input logic             disp_valid_i,
    input logic [PC_W-1:0]  disp_pc_i,
    input logic [SEQ_W-1:0] disp_seq_i,
    input logic             iss_valid_i,
    input logic             iss_is_store_i,
    input logic [PC_W-1:0]  iss_pc_i,
    input logic [SEQ_W-1:0] iss_seq_i,
    input logic             sq_valid_i,
    input logic [SEQ_W-1:0] sq_seq_i,
    input logic             clr_i,
    input logic [PC_W-1:0]  lk_pc_i,
    input logic             lk_dep_o,
    input logic [SEQ_W-1:0] lk_seq_o,
    input logic [CNT_W-1:0] lk_pending_o,
    input logic             st_disp_en
);

    // R9: the cycle after a clear every lookup is empty.
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (!lk_dep_o && lk_pending_o == '0));

    // R5: an accepted store dispatch is visible to a lookup of the same PC next cycle.
    p_store_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_disp_en && !clr_i && !sq_valid_i && !iss_valid_i) &&
         lk_pc_i == $past(disp_pc_i))
        |-> (lk_dep_o && lk_seq_o == $past(disp_seq_i)));

    // R8: after a squash no reported store is younger than the squash point.
    p_squash_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sq_valid_i) && lk_dep_o) |-> (lk_seq_o <= $past(sq_seq_i)));

    // R7: issuing the very store a lookup waited on releases that lookup.
    p_issue_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(iss_valid_i && iss_is_store_i && !disp_valid_i && !viol_valid_i &&
               lk_dep_o && lk_seq_o == iss_seq_i && lk_pc_i == iss_pc_i) &&
         $stable(lk_pc_i))
        |-> !lk_dep_o);

endmodule

bind ssp_top ssp_top_checker #(
    .PC_W  (PC_W),
    .SEQ_W (SEQ_W),
    .CNT_W (CNT_W)
) chk (.*);

// File: tb/ssp_top_test.sv
module ssp_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int SSIT_N     = 64;
    localparam int LFST_N     = 16;
    localparam int CNT_MAX    = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        viol_valid_i = 1'b0;
    logic [31:0] viol_st_pc_i = '0;
    logic [31:0] viol_ld_pc_i = '0;
    logic        disp_valid_i = 1'b0;
    logic        disp_is_store_i = 1'b0;
    logic [31:0] disp_pc_i = '0;
    logic [15:0] disp_seq_i = '0;
    logic        iss_valid_i = 1'b0;
    logic        iss_is_store_i = 1'b0;
    logic [31:0] iss_pc_i = '0;
    logic [15:0] iss_seq_i = '0;
    logic        sq_valid_i = 1'b0;
    logic [15:0] sq_seq_i = '0;
    logic        clr_i = 1'b0;
    logic [31:0] lk_pc_i = '0;
    logic        lk_dep_o;
    logic [15:0] lk_seq_o;
    logic [3:0]  lk_pending_o;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state.
    int m_sv [SSIT_N];
    int m_sid [SSIT_N];
    int m_lv [LFST_N];
    int m_lseq [LFST_N];
    int m_cnt [LFST_N];

    ssp_top uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int m_idx(input logic [31:0] pc);
        return int'((pc >> 2) & 32'd63);
    endfunction

    function automatic int m_hash(input logic [31:0] pc);
        return int'((pc ^ (pc >> 10)) & 32'd15);
    endfunction

    task automatic m_clear();
        for (int i = 0; i < SSIT_N; i++) begin m_sv[i] = 0; m_sid[i] = 0; end
        for (int i = 0; i < LFST_N; i++) begin m_lv[i] = 0; m_lseq[i] = 0; m_cnt[i] = 0; end
    endtask

    // Apply one cycle's operations in order: violation, dispatch, issue, squash.
    task automatic m_step();
        int li, si, t, d, k;
        if (clr_i) begin m_clear(); return; end
        if (viol_valid_i) begin
            li = m_idx(viol_ld_pc_i);
            si = m_idx(viol_st_pc_i);
            if (!m_sv[li] && !m_sv[si])     t = m_hash(viol_ld_pc_i);
            else if (m_sv[li] && !m_sv[si]) t = m_sid[li];
            else if (!m_sv[li] && m_sv[si]) t = m_sid[si];
            else t = (m_sid[li] < m_sid[si]) ? m_sid[li] : m_sid[si];
            m_sv[li] = 1; m_sid[li] = t;
            m_sv[si] = 1; m_sid[si] = t;
        end
        if (disp_valid_i && disp_is_store_i && m_sv[m_idx(disp_pc_i)]) begin
            d = m_sid[m_idx(disp_pc_i)];
            m_lv[d] = 1; m_lseq[d] = int'(disp_seq_i);
            if (m_cnt[d] < CNT_MAX) m_cnt[d]++;
        end
        if (iss_valid_i && iss_is_store_i && m_sv[m_idx(iss_pc_i)]) begin
            k = m_sid[m_idx(iss_pc_i)];
            if (m_lv[k] && m_lseq[k] == int'(iss_seq_i)) m_lv[k] = 0;
            if (m_cnt[k] > 0) m_cnt[k]--;
        end
        if (sq_valid_i) begin
            for (int i = 0; i < LFST_N; i++)
                if (m_lv[i] && m_lseq[i] > int'(sq_seq_i)) m_lv[i] = 0;
        end
    endtask

    task automatic model_compare(input string tag);
        int i, e_dep, e_seq, e_pend;
        i = m_idx(lk_pc_i);
        e_dep = 0; e_seq = 0; e_pend = 0;
        if (m_sv[i]) begin
            e_pend = m_cnt[m_sid[i]];
            if (m_lv[m_sid[i]]) begin e_dep = 1; e_seq = m_lseq[m_sid[i]]; end
        end
        checks++;
        if (int'(lk_dep_o) != e_dep || int'(lk_seq_o) != e_seq || int'(lk_pending_o) != e_pend) begin
            errors++;
            $display("FAIL %s model: dep/seq/pend got %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, lk_dep_o, lk_seq_o, lk_pending_o, e_dep, e_seq, e_pend);
        end
    endtask

    task automatic clear_ops();
        viol_valid_i = 1'b0; disp_valid_i = 1'b0; iss_valid_i = 1'b0;
        sq_valid_i = 1'b0; clr_i = 1'b0;
    endtask

    // Inputs are set after a falling edge; compare, then advance one clock.
    task automatic step(input string tag);
        #1;
        model_compare(tag);
        @(posedge clk);
        m_step();
        @(negedge clk);
        clear_ops();
    endtask

    task automatic look(input logic [31:0] pc, input string tag,
                        input int e_dep, input int e_seq, input int e_pend);
        lk_pc_i = pc;
        #1;
        checks++;
        if (int'(lk_dep_o) != e_dep || int'(lk_seq_o) != e_seq ||
            (e_pend >= 0 && int'(lk_pending_o) != e_pend)) begin
            errors++;
            $display("FAIL %s pc=%h: dep/seq/pend got %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, pc, lk_dep_o, lk_seq_o, lk_pending_o, e_dep, e_seq, e_pend);
        end
        step(tag);
    endtask

    task automatic viol(input logic [31:0] st, input logic [31:0] ld);
        viol_valid_i = 1'b1; viol_st_pc_i = st; viol_ld_pc_i = ld;
    endtask

    task automatic disp(input logic st, input logic [31:0] pc, input int seq);
        disp_valid_i = 1'b1; disp_is_store_i = st; disp_pc_i = pc; disp_seq_i = 16'(seq);
    endtask

    task automatic issue(input logic st, input logic [31:0] pc, input int seq);
        iss_valid_i = 1'b1; iss_is_store_i = st; iss_pc_i = pc; iss_seq_i = 16'(seq);
    endtask

    task automatic squash(input int seq);
        sq_valid_i = 1'b1; sq_seq_i = 16'(seq);
    endtask

    function automatic logic [31:0] rand_pc();
        return 32'(($urandom_range(0, 3) << 10) | ($urandom_range(0, 23) << 2) | $urandom_range(0, 3));
    endfunction

    localparam logic [31:0] L1 = 32'h104, S1 = 32'h208, L2 = 32'h415, S2 = 32'h220;
    localparam logic [31:0] S3 = 32'h230, L3 = 32'h140, S4 = 32'h24C, L4 = 32'h150;
    localparam logic [31:0] S5 = 32'h360, L5 = 32'h370, UNTRAINED = 32'h3F0;

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int next_seq;
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: empty after reset.
        look(L1, "R11", 0, 0, 0);
        look(S5, "R11", 0, 0, 0);

        // R2: fresh pair B takes the load hash (4), shared with pair A's hash.
        viol(S2, L2); step("R2");
        viol(S1, L1); step("R2");
        disp(1'b1, S1, 10); lk_pc_i = L2; step("R6");
        look(L2, "R2", 1, 10, 1);

        // R3: one valid side is adopted, in either direction.
        viol(S3, L1); step("R3");
        disp(1'b1, S3, 20); step("R3");
        look(L1, "R3", 1, 20, 2);
        look(32'h107, "R1", 1, 20, 2);
        look(32'h504, "R1", 1, 20, 2);
        viol(S1, L3); step("R3");
        look(L3, "R3", 1, 20, 2);

        // R4: both valid, lower identifier wins.
        viol(S4, L4); step("R4");
        viol(S4, L1); step("R4");
        look(L1, "R4", 0, 0, 0);
        disp(1'b1, S4, 30); step("R4");
        look(L1, "R4", 1, 30, 1);
        look(L2, "R4", 1, 20, 2);

        // R5: untrained store and load dispatches change nothing; counter saturates.
        disp(1'b1, UNTRAINED, 40); step("R5");
        look(UNTRAINED, "R5", 0, 0, 0);
        disp(1'b0, L1, 41); step("R5");
        look(L1, "R5", 1, 30, 1);
        for (int n = 0; n < 20; n++) begin disp(1'b1, S4, 50 + n); step("R5"); end
        look(L1, "R5", 1, 69, CNT_MAX);

        // R7: stale issue only decrements; load issue is ignored; matching issue frees.
        issue(1'b1, S4, 50); step("R7");
        look(L1, "R7", 1, 69, 14);
        issue(1'b0, L1, 69); step("R7");
        look(L1, "R7", 1, 69, 14);
        issue(1'b1, S4, 69); step("R7");
        look(L1, "R7", 0, 0, 13);

        // R8: squash keeps equal numbers, removes younger ones.
        disp(1'b1, S4, 100); step("R8");
        look(L1, "R8", 1, 100, 14);
        squash(100); step("R8");
        look(L1, "R8", 1, 100, 14);
        squash(99); step("R8");
        look(L1, "R8", 0, 0, 14);

        // R10: violation then dispatch in one cycle; lookup in that cycle sees old state.
        viol(S5, L5); disp(1'b1, S5, 200); lk_pc_i = L5;
        #1;
        checks++;
        if (lk_dep_o !== 1'b0 || lk_pending_o !== 4'd0) begin
            errors++;
            $display("FAIL R6 same-cycle lookup: dep/pend got %0d/%0d expected 0/0", lk_dep_o, lk_pending_o);
        end
        step("R10");
        look(L5, "R10", 1, 200, 15);
        disp(1'b1, S5, 201); issue(1'b1, S5, 201); step("R10");
        look(L5, "R10", 0, 0, 14);

        // R9: clear wins over a same-cycle dispatch.
        clr_i = 1'b1; disp(1'b1, S5, 300); step("R9");
        look(L5, "R9", 0, 0, 0);
        look(L1, "R9", 0, 0, 0);

        // Random mix, compared with the reference every cycle.
        next_seq = 400;
        for (int n = 0; n < 6000; n++) begin
            lk_pc_i = rand_pc();
            if ($urandom_range(0, 3) == 0) viol(rand_pc(), rand_pc());
            if ($urandom_range(0, 1) == 0) begin
                disp($urandom_range(0, 3) != 0, rand_pc(), next_seq);
                next_seq++;
            end
            if ($urandom_range(0, 2) == 0) issue($urandom_range(0, 3) != 0, rand_pc(), next_seq - int'($urandom_range(1, 4)));
            if ($urandom_range(0, 40) == 0) squash(next_seq - int'($urandom_range(0, 8)));
            if ($urandom_range(0, 400) == 0) begin clr_i = 1'b1; next_seq = 400; end
            step("R10");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule